// File: doc/BRIEF.md
# Non-Blocking Load Queue Tracker

This block keeps track of loads that have been issued to a non-blocking data cache. A load that hits is written back at once, with no wait. A load that misses takes one of a fixed set of queue slots and records three things there: its destination register tag, its line address and its word offset. The slot then waits until the fill path reports that its line has returned. Because of this, a younger hit can write its register before an older miss does, so register writebacks leave the block out of program order.

When a fill-return names a line, every slot waiting on that line becomes ready. Ready slots drain one writeback per cycle, oldest first. A hit issued in the same cycle as a pending miss writeback takes the writeback port, and the miss goes on the next cycle. Issue is held off when every slot is taken or when the fill buffer reports that it has no room. The cache arrays, the fill data and the register file sit outside this block. The writeback event gives the line and offset so that the data path can fetch the word.

Top module: `ldq_tracker`

## Requirements
- R1: After reset, `wb_valid` is 0 and, with `fsb_full` low, `stall` is 0.
- R2: A hit accepted in cycle t produces `wb_valid`=1, `wb_miss`=0 and its own tag, line and offset in cycle t+1. This holds even when older misses are still waiting, so a younger hit overtakes them.
- R3: An accepted miss holds a slot and produces no writeback until a fill-return names its line address.
- R4: A fill-return in cycle t makes every slot waiting on `fill_line` ready, starting from cycle t+1. Ready slots write back one per cycle (`wb_miss`=1), oldest issue first, each appearing one cycle after it is selected. Slots waiting on other lines are not affected.
- R5: When a hit is accepted in a cycle where a ready miss could write back, the hit's writeback goes first and the miss follows in a later cycle.
- R6: `stall` is 1 whenever all DEPTH (default 9) slots are held, so at most DEPTH misses are outstanding.
- R7: `stall` is 1 in every cycle where `fsb_full` is 1.
- R8: A load presented while `stall` is 1 is ignored: it produces no writeback and takes no slot.
- R9: A miss accepted in the same cycle as a fill-return for its own line is ready at once and writes back two cycles after issue, provided no older ready slot or hit is ahead of it.
- R10: A slot is freed in the cycle its writeback is selected. With a full queue and `fsb_full` low, `stall` falls after the edge at which the first writeback is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A load is presented for issue |
| iss_hit | input | 1 | The presented load hits in the cache |
| iss_tag | input | TAG_W | Destination register tag |
| iss_line | input | LINE_W | Line address of the load |
| iss_ofs | input | OFS_W | Word offset within the line |
| fill_valid | input | 1 | A line has returned from memory |
| fill_line | input | LINE_W | Line address of the returned line |
| fsb_full | input | 1 | The fill buffer has no free entry |
| stall | output | 1 | Issue is held off this cycle |
| wb_valid | output | 1 | A register writeback event is valid |
| wb_miss | output | 1 | The writeback belongs to a load that missed |
| wb_tag | output | TAG_W | Destination tag of the writeback |
| wb_line | output | LINE_W | Line address of the written-back load |
| wb_ofs | output | OFS_W | Word offset of the written-back load |

## Verification
Directed patterns cover the following cases:
- A single miss followed by a hit. This separates in-order completion from out-of-order completion.
- Several misses on one line interleaved with a miss on another line, followed by a fill. This shows whether the fill releases exactly the matching slots and whether they drain in age order.
- A fill followed by a hit in the next cycle. This shows which source wins the writeback port.
- A miss that meets its own fill in the issue cycle.
- Nine misses followed by a tenth load. This exposes the full-queue stall and confirms the tenth load is dropped.

Random stimulus then mixes hits, misses on a few shared lines, fills and fill-buffer back-pressure. It compares every writeback field and the stall output against a reference model, which shows up ordering errors that only appear when fills and issues overlap.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_READY = 2'd2
   } slot_state_e;

endpackage

// File: rtl/ldq_slot.sv
module ldq_slot
   import ldq_pkg::*;
#(
   parameter int TAG_W       = 5,
   parameter int LINE_W      = 26,
   parameter int OFS_W       = 4,
   parameter bit FILL_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic [LINE_W-1:0] a_line,
   input  logic [OFS_W-1:0]  a_ofs,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              rel,
   output logic              busy,
   output logic              ready,
   output logic [TAG_W-1:0]  s_tag,
   output logic [LINE_W-1:0] s_line,
   output logic [OFS_W-1:0]  s_ofs
);

   slot_state_e       st_q, st_d;
   logic [TAG_W-1:0]  tag_q;
   logic [LINE_W-1:0] line_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              own_match;
   logic              alloc_ready;

   assign own_match = fill_valid && (fill_line == line_q);

   generate
      if (FILL_BYPASS) begin : g_bypass
         assign alloc_ready = fill_valid && (fill_line == a_line);
      end else begin : g_no_bypass
         assign alloc_ready = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SLOT_IDLE:  if (alloc) st_d = alloc_ready ? SLOT_READY : SLOT_WAIT;
         SLOT_WAIT:  if (own_match) st_d = SLOT_READY;
         SLOT_READY: if (rel) st_d = SLOT_IDLE;
         default:    st_d = SLOT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SLOT_IDLE;
         tag_q  <= '0;
         line_q <= '0;
         ofs_q  <= '0;
      end else begin
         st_q <= st_d;
         if (alloc && st_q == SLOT_IDLE) begin
            tag_q  <= a_tag;
            line_q <= a_line;
            ofs_q  <= a_ofs;
         end
      end
   end

   assign busy   = (st_q != SLOT_IDLE);
   assign ready  = (st_q == SLOT_READY);
   assign s_tag  = tag_q;
   assign s_line = line_q;
   assign s_ofs  = ofs_q;

endmodule

// File: rtl/ldq_free_pick.sv
module ldq_free_pick #(
   parameter int DEPTH = 9
) (
   input  logic [DEPTH-1:0] busy,
   output logic [DEPTH-1:0] pick,
   output logic             any_free
);

   always_comb begin
      pick     = '0;
      any_free = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!busy[i] && !any_free) begin
            pick[i]  = 1'b1;
            any_free = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ldq_age_matrix.sv
module ldq_age_matrix #(
   parameter int DEPTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc_vec,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant
);

   // older_q[i][j] set means slot i was filled before slot j
   logic [DEPTH-1:0] older_q [DEPTH];
   logic [DEPTH-1:0] col     [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
      end else if (|alloc_vec) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_vec[i]) older_q[i] <= '0;
            else              older_q[i] <= older_q[i] | alloc_vec;
         end
      end
   end

   genvar gi, gj;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_col
         for (gj = 0; gj < DEPTH; gj++) begin : g_bit
            assign col[gi][gj] = (gi != gj) && older_q[gj][gi];
         end
         assign grant[gi] = req[gi] && !(|(req & col[gi]));
      end
   endgenerate

endmodule

// File: rtl/ldq_tracker.sv
module ldq_tracker
   import ldq_pkg::*;
#(
   parameter int DEPTH       = 9,
   parameter int TAG_W       = 5,
   parameter int LINE_W      = 26,
   parameter int OFS_W       = 4,
   parameter bit FILL_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_hit,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [LINE_W-1:0] iss_line,
   input  logic [OFS_W-1:0]  iss_ofs,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fsb_full,
   output logic              stall,
   output logic              wb_valid,
   output logic              wb_miss,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [LINE_W-1:0] wb_line,
   output logic [OFS_W-1:0]  wb_ofs
);

   localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("ldq_tracker: DEPTH must be at least 2"); end
      if (TAG_W < 1)  begin : g_bad_tag   $error("ldq_tracker: TAG_W must be positive"); end
      if (LINE_W < 1) begin : g_bad_line  $error("ldq_tracker: LINE_W must be positive"); end
      if (OFS_W < 1)  begin : g_bad_ofs   $error("ldq_tracker: OFS_W must be positive"); end
      if (SEL_W < 1)  begin : g_bad_sel   $error("ldq_tracker: select width invalid"); end
   endgenerate

   logic [DEPTH-1:0]  busy_vec, ready_vec, free_pick, grant, alloc_vec, rel_vec;
   logic              any_free, accept, hit_take, miss_take;
   logic [TAG_W-1:0]  slot_tag  [DEPTH];
   logic [LINE_W-1:0] slot_line [DEPTH];
   logic [OFS_W-1:0]  slot_ofs  [DEPTH];
   logic [TAG_W-1:0]  sel_tag;
   logic [LINE_W-1:0] sel_line;
   logic [OFS_W-1:0]  sel_ofs;

   assign stall     = (&busy_vec) || fsb_full;
   assign accept    = iss_valid && !stall;
   assign hit_take  = accept && iss_hit;
   assign alloc_vec = (accept && !iss_hit && any_free) ? free_pick : '0;
   assign miss_take = (|grant) && !hit_take;
   assign rel_vec   = miss_take ? grant : '0;

   ldq_free_pick #(.DEPTH(DEPTH)) u_pick (
      .busy     (busy_vec),
      .pick     (free_pick),
      .any_free (any_free)
   );

   ldq_age_matrix #(.DEPTH(DEPTH)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_vec (alloc_vec),
      .req       (ready_vec),
      .grant     (grant)
   );

   genvar gs;
   generate
      for (gs = 0; gs < DEPTH; gs++) begin : g_slot
         ldq_slot #(
            .TAG_W       (TAG_W),
            .LINE_W      (LINE_W),
            .OFS_W       (OFS_W),
            .FILL_BYPASS (FILL_BYPASS)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (alloc_vec[gs]),
            .a_tag      (iss_tag),
            .a_line     (iss_line),
            .a_ofs      (iss_ofs),
            .fill_valid (fill_valid),
            .fill_line  (fill_line),
            .rel        (rel_vec[gs]),
            .busy       (busy_vec[gs]),
            .ready      (ready_vec[gs]),
            .s_tag      (slot_tag[gs]),
            .s_line     (slot_line[gs]),
            .s_ofs      (slot_ofs[gs])
         );
      end
   endgenerate

   // one-hot read of the granted slot
   always_comb begin
      sel_tag  = '0;
      sel_line = '0;
      sel_ofs  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) begin
            sel_tag  = sel_tag  | slot_tag[i];
            sel_line = sel_line | slot_line[i];
            sel_ofs  = sel_ofs  | slot_ofs[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_miss  <= 1'b0;
         wb_tag   <= '0;
         wb_line  <= '0;
         wb_ofs   <= '0;
      end else begin
         wb_valid <= hit_take || miss_take;
         wb_miss  <= miss_take;
         if (hit_take) begin
            wb_tag  <= iss_tag;
            wb_line <= iss_line;
            wb_ofs  <= iss_ofs;
         end else if (miss_take) begin
            wb_tag  <= sel_tag;
            wb_line <= sel_line;
            wb_ofs  <= sel_ofs;
         end
      end
   end

endmodule

// File: rtl/ldq_tracker_chk.sv
module ldq_tracker_chk #(
   parameter int DEPTH = 9,
   parameter int TAG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic             iss_hit,
   input logic [TAG_W-1:0] iss_tag,
   input logic             fsb_full,
   input logic             stall,
   input logic             wb_valid,
   input logic             wb_miss,
   input logic [TAG_W-1:0] wb_tag,
   input logic [DEPTH-1:0] busy_vec,
   input logic [DEPTH-1:0] ready_vec
);

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !stall && iss_hit) |=> (wb_valid && !wb_miss && wb_tag == $past(iss_tag))); // R2

   AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|ready_vec) && !(iss_valid && !stall && iss_hit)) |=> !wb_valid); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_vec) |-> stall); // R6

   AST_FSB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      fsb_full |-> stall); // R7

   AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($countones(busy_vec) <= $past($countones(busy_vec)))); // R8

endmodule

bind ldq_tracker ldq_tracker_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_hit   (iss_hit),
   .iss_tag   (iss_tag),
   .fsb_full  (fsb_full),
   .stall     (stall),
   .wb_valid  (wb_valid),
   .wb_miss   (wb_miss),
   .wb_tag    (wb_tag),
   .busy_vec  (busy_vec),
   .ready_vec (ready_vec)
);

// File: tb/ldq_tracker_test.sv
module ldq_tracker_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 9;
   localparam int TAG_W  = 5;
   localparam int LINE_W = 26;
   localparam int OFS_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              iss_valid, iss_hit, fill_valid, fsb_full;
   logic [TAG_W-1:0]  iss_tag;
   logic [LINE_W-1:0] iss_line, fill_line;
   logic [OFS_W-1:0]  iss_ofs;
   logic              stall, wb_valid, wb_miss;
   logic [TAG_W-1:0]  wb_tag;
   logic [LINE_W-1:0] wb_line;
   logic [OFS_W-1:0]  wb_ofs;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldq_tracker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_W(LINE_W), .OFS_W(OFS_W)) uut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_hit(iss_hit),
      .iss_tag(iss_tag), .iss_line(iss_line), .iss_ofs(iss_ofs),
      .fill_valid(fill_valid), .fill_line(fill_line), .fsb_full(fsb_full),
      .stall(stall), .wb_valid(wb_valid), .wb_miss(wb_miss),
      .wb_tag(wb_tag), .wb_line(wb_line), .wb_ofs(wb_ofs)
   );

   // reference model
   bit                m_valid [DEPTH];
   bit                m_ready [DEPTH];
   logic [TAG_W-1:0]  m_tag   [DEPTH];
   logic [LINE_W-1:0] m_line  [DEPTH];
   logic [OFS_W-1:0]  m_ofs   [DEPTH];
   int unsigned       m_seq   [DEPTH];
   int unsigned       seq_ctr;
   bit                e_valid, e_miss;
   logic [TAG_W-1:0]  e_tag;
   logic [LINE_W-1:0] e_line;
   logic [OFS_W-1:0]  e_ofs;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   function automatic int m_count();
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (m_valid[i]) n++;
      return n;
   endfunction

   function automatic bit exp_stall(bit ff);
      return (m_count() == DEPTH) || ff;
   endfunction

   function automatic int oldest_ready();
      int best = -1;
      for (int i = 0; i < DEPTH; i++)
         if (m_valid[i] && m_ready[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
      return best;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check stall, update model, check wb at next negedge
   task automatic step(bit v, bit h, logic [TAG_W-1:0] t, logic [LINE_W-1:0] l,
                       logic [OFS_W-1:0] o, bit fv, logic [LINE_W-1:0] fl, bit ff, string req);
      bit es, acc;
      int sel;
      string lbl;
      iss_valid = v; iss_hit = h; iss_tag = t; iss_line = l; iss_ofs = o;
      fill_valid = fv; fill_line = fl; fsb_full = ff;
      #1;
      es  = exp_stall(ff);
      lbl = (req != "") ? req : (ff ? "R7" : (m_count() == DEPTH ? "R6" : "R10"));
      chk(stall == es, lbl, "stall", stall, es);
      acc = v && !es;
      e_valid = 1'b0; e_miss = 1'b0;
      if (acc && h) begin
         e_valid = 1'b1; e_tag = t; e_line = l; e_ofs = o;
      end else begin
         sel = oldest_ready();
         if (sel >= 0) begin
            e_valid = 1'b1; e_miss = 1'b1;
            e_tag = m_tag[sel]; e_line = m_line[sel]; e_ofs = m_ofs[sel];
            m_valid[sel] = 1'b0; m_ready[sel] = 1'b0;
         end
      end
      if (fv)
         for (int i = 0; i < DEPTH; i++)
            if (m_valid[i] && !m_ready[i] && m_line[i] == fl) m_ready[i] = 1'b1;
      if (acc && !h) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (!m_valid[i]) begin
               m_valid[i] = 1'b1; m_ready[i] = fv && (fl == l);
               m_tag[i] = t; m_line[i] = l; m_ofs[i] = o; m_seq[i] = seq_ctr++;
               break;
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      lbl = (req != "") ? req : (!e_valid ? "R3" : (e_miss ? "R4" : "R2"));
      chk(wb_valid == e_valid, lbl, "wb_valid", wb_valid, e_valid);
      if (e_valid) begin
         chk(wb_miss == e_miss, lbl, "wb_miss", wb_miss, e_miss);
         chk(wb_tag  == e_tag,  lbl, "wb_tag",  wb_tag,  e_tag);
         chk(wb_line == e_line, lbl, "wb_line", wb_line, e_line);
         chk(wb_ofs  == e_ofs,  lbl, "wb_ofs",  wb_ofs,  e_ofs);
      end
   endtask

   task automatic idle(bit fv, logic [LINE_W-1:0] fl, string req);
      step(1'b0, 1'b0, '0, '0, '0, fv, fl, 1'b0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      seq_ctr = 0;
      for (int i = 0; i < DEPTH; i++) begin m_valid[i] = 0; m_ready[i] = 0; end
      rst_n = 1'b0; iss_valid = 0; iss_hit = 0; iss_tag = '0; iss_line = '0; iss_ofs = '0;
      fill_valid = 0; fill_line = '0; fsb_full = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
      chk(stall == 1'b0,    "R1", "stall after reset",    stall, 0);

      // R2: younger hit overtakes older miss
      step(1, 0, 5'd1, 26'h100, 4'd1, 0, '0, 0, "R3");
      step(1, 1, 5'd2, 26'h200, 4'd2, 0, '0, 0, "R2");
      // R4: two more on line 100, one on line 300; fill 100 drains oldest first
      step(1, 0, 5'd3, 26'h100, 4'd3, 0, '0, 0, "R3");
      step(1, 0, 5'd4, 26'h300, 4'd4, 0, '0, 0, "R3");
      step(1, 0, 5'd5, 26'h100, 4'd5, 0, '0, 0, "R3");
      idle(1, 26'h100, "R4");
      repeat (4) idle(0, '0, "R4");
      // R5: line 300 becomes ready, a hit in the next cycle takes the port first
      idle(1, 26'h300, "R5");
      step(1, 1, 5'd6, 26'h400, 4'd6, 0, '0, 0, "R5");
      repeat (2) idle(0, '0, "R5");
      // R9: miss meets its own fill in the issue cycle
      step(1, 0, 5'd7, 26'h500, 4'd7, 1, 26'h500, 0, "R9");
      repeat (2) idle(0, '0, "R9");
      // R6: fill the queue, then a tenth load is refused (R8)
      for (int i = 0; i < DEPTH; i++) step(1, 0, 5'(8 + i), 26'h600, 4'(i), 0, '0, 0, "R6");
      step(1, 1, 5'd30, 26'h700, 4'd0, 0, '0, 0, "R8");
      step(1, 0, 5'd31, 26'h700, 4'd1, 0, '0, 0, "R8");
      // R10: fill frees slots one per cycle, stall drops
      idle(1, 26'h600, "R10");
      for (int i = 0; i < DEPTH + 1; i++) idle(0, '0, "R10");
      // R7 and R8: fill buffer back-pressure blocks a hit
      step(1, 1, 5'd12, 26'h800, 4'd2, 0, '0, 1, "R7");
      step(1, 0, 5'd13, 26'h800, 4'd3, 0, '0, 1, "R8");
      idle(0, '0, "R8");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         bit v, h, fv, ff;
         logic [LINE_W-1:0] l, fl;
         v  = ($urandom % 10) < 6;
         h  = ($urandom % 2) == 0;
         fv = ($urandom % 100) < 15;
         ff = ($urandom % 100) < 10;
         l  = LINE_W'(26'h1000 + ($urandom % 4));
         fl = LINE_W'(26'h1000 + ($urandom % 4));
         step(v, h, TAG_W'($urandom), l, OFS_W'($urandom), fv, fl, ff, "");
      end
      for (int i = 0; i < 4; i++) idle(1, LINE_W'(26'h1000 + i), "");
      repeat (DEPTH + 2) idle(0, '0, "");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule